// File: doc/BRIEF.md
# Selectable-Timebase Event Counter

This block is a 16-bit free-running up-counter. What makes it advance is chosen by a small mode register. The choices are a divided-down system clock (by 12 or by 4), the system clock itself, a one-cycle overflow pulse from a neighbouring timer, falling edges on an asynchronous external count pin, and an asynchronous external clock divided by 8. Both external pins are brought into the system clock domain before use. Each of them then becomes a single-cycle count enable, so the counter register always runs on the system clock.

Software writes the 8-bit mode register through a write strobe and reads it back through a read strobe. Besides the source select, the register holds two further controls. One freezes the counter while the CPU reports idle. The other lets the sticky wrap flag raise an interrupt request. When the counter rolls over from all ones to zero it sets the flag, and only a dedicated clear strobe lowers it again.

Top module: `tbsel_counter`

## Requirements
- R1: After synchronous reset the count is 0, the wrap flag and the interrupt request are low, and the mode register reads 0x00.
- R2: While the read strobe is high, the read data is {bit7 idle-hold, 3'b000, bits 3..1 source select, bit0 interrupt enable}. Writes to bits 6..4 are dropped. While the read strobe is low the read data is 0x00.
- R3: Source code 000 advances the count by exactly 10 in any 120 consecutive clock cycles (system clock / 12).
- R4: Source code 001 advances the count by exactly 10 in any 40 consecutive clock cycles (system clock / 4).
- R5: Source code 010 advances the count by 1 for each clock cycle in which the timer overflow input is high.
- R6: Source code 011 advances the count by 1 for each high-to-low transition of the external count pin, when each level is held at least 2 cycles. A pin held steady adds nothing.
- R7: Source code 100 advances the count by 1 on every clock cycle.
- R8: Source code 101 advances the count by 1 for every 8 rising edges of the external clock pin. The divider starts from zero at reset, so the 8th and 16th edges after reset each add one.
- R9: Source codes 110 and 111 hold the count still.
- R10: With mode bit 7 set, the count holds while the CPU idle input is high. With bit 7 clear, the idle input has no effect.
- R11: A step from 0xFFFF to 0x0000 sets the wrap flag. The flag stays set until the clear strobe is applied. When a wrap and the clear strobe fall in the same cycle, the flag ends up set.
- R12: The interrupt request is high exactly when the wrap flag is set and mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| t0_ovf_i | input | 1 | One-cycle overflow pulse from timer 0 |
| ext_clk_i | input | 1 | Asynchronous external clock, divided by 8 |
| ext_cnt_i | input | 1 | Asynchronous external count pin, falling edges counted |
| cpu_idle_i | input | 1 | CPU idle indication |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_rd_i | input | 1 | Mode register read strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_rdata_o | output | 8 | Mode register read data |
| ovf_clr_i | input | 1 | Clear strobe for the wrap flag |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Two events can land in the same cycle: the counter wrapping past 0xFFFF and software clearing the flag. The bench runs the counter on the system clock until it reads 0xFFFF. It then asserts the clear strobe for exactly the cycle in which the wrap occurs. On the next sample it expects the count to be zero and the flag to be set, because setting has priority over clearing. It then checks that a later lone clear strobe does lower the flag and the interrupt request.

// File: rtl/tbsel_pkg.sv
package tbsel_pkg;

  typedef enum logic [2:0] {
    SRC_DIV_SLOW = 3'b000,
    SRC_DIV_FAST = 3'b001,
    SRC_T0_OVF   = 3'b010,
    SRC_EXT_CNT  = 3'b011,
    SRC_SYSCLK   = 3'b100,
    SRC_EXT_DIV  = 3'b101,
    SRC_RSVD_A   = 3'b110,
    SRC_RSVD_B   = 3'b111
  } src_e;

  typedef struct packed {
    logic idle_hold;
    src_e src;
    logic irq_en;
  } mode_t;

  function automatic mode_t mode_from_bus(input logic [7:0] d);
    mode_t m;
    m.idle_hold = d[7];
    m.src       = src_e'(d[3:1]);
    m.irq_en    = d[0];
    return m;
  endfunction

  function automatic logic [7:0] mode_to_bus(input mode_t m);
    return {m.idle_hold, 3'b000, m.src, m.irq_en};
  endfunction

  function automatic logic src_is_reserved(input src_e s);
    return (s == SRC_RSVD_A) || (s == SRC_RSVD_B);
  endfunction

endpackage

// File: rtl/tbsel_modcnt.sv
module tbsel_modcnt #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (en)   cnt_q <= tick ? '0 : cnt_q + W'(1);
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R4
    end
  endgenerate

endmodule

// File: rtl/tbsel_sync_edge.sv
module tbsel_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= level;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q && !level;
    end else begin : g_rise
      assign edge_o = !prev_q && level;
    end
  endgenerate

endmodule

// File: rtl/tbsel_counter.sv
module tbsel_counter
  import tbsel_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             t0_ovf_i,
  input  logic             ext_clk_i,
  input  logic             ext_cnt_i,
  input  logic             cpu_idle_i,
  input  logic             mode_wr_i,
  input  logic             mode_rd_i,
  input  logic [7:0]       mode_wdata_i,
  output logic [7:0]       mode_rdata_o,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  mode_t            mode_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_flag_q;

  // named internal events
  logic tick_slow, tick_fast, tick_extcnt, ext_rise, tick_extdiv;
  logic src_tick, run_ok, inc, wrap_evt;

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= '0;
    else if (mode_wr_i) mode_q <= mode_from_bus(mode_wdata_i);
  end

  assign mode_rdata_o = mode_rd_i ? mode_to_bus(mode_q) : 8'h00;

  tbsel_modcnt #(.DIV(SLOW_DIV)) u_slow (
    .clk(clk), .rst(rst), .en(1'b1), .tick(tick_slow));

  tbsel_modcnt #(.DIV(FAST_DIV)) u_fast (
    .clk(clk), .rst(rst), .en(1'b1), .tick(tick_fast));

  tbsel_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_cnt_pin (
    .clk(clk), .rst(rst), .pin_i(ext_cnt_i), .edge_o(tick_extcnt));

  tbsel_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_clk_pin (
    .clk(clk), .rst(rst), .pin_i(ext_clk_i), .edge_o(ext_rise));

  tbsel_modcnt #(.DIV(EXT_DIV)) u_ext_div (
    .clk(clk), .rst(rst), .en(ext_rise), .tick(tick_extdiv));

  always_comb begin
    unique case (mode_q.src)
      SRC_DIV_SLOW: src_tick = tick_slow;
      SRC_DIV_FAST: src_tick = tick_fast;
      SRC_T0_OVF:   src_tick = t0_ovf_i;
      SRC_EXT_CNT:  src_tick = tick_extcnt;
      SRC_SYSCLK:   src_tick = 1'b1;
      SRC_EXT_DIV:  src_tick = tick_extdiv;
      default:      src_tick = 1'b0;
    endcase
  end

  assign run_ok   = !(mode_q.idle_hold && cpu_idle_i);
  assign inc      = src_tick && run_ok;
  assign wrap_evt = inc && (count_q == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst)      count_q <= '0;
    else if (inc) count_q <= count_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)            ovf_flag_q <= 1'b0;
    else if (wrap_evt)  ovf_flag_q <= 1'b1;
    else if (ovf_clr_i) ovf_flag_q <= 1'b0;
  end

  assign count_o    = count_q;
  assign ovf_flag_o = ovf_flag_q;
  assign irq_o      = ovf_flag_q && mode_q.irq_en;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    inc |=> count_q == $past(count_q) + CNT_W'(1)); // R7
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    src_is_reserved(mode_q.src) |=> $stable(count_q)); // R9
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (mode_q.idle_hold && cpu_idle_i) |=> $stable(count_q)); // R10
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (ovf_flag_q && count_q == '0)); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag_q && !ovf_clr_i) |=> ovf_flag_q); // R11
  AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag_q) |-> $past(wrap_evt)); // R11
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ovf_flag_q); // R12
  AST_READ_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    mode_wr_i |=> (mode_rd_i ? mode_rdata_o[6:4] == 3'b000 : 1'b1)); // R2

endmodule

// File: tb/tb_tbsel_counter.sv
module tb_tbsel_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        t0_ovf = 1'b0, ext_clk = 1'b0, ext_cnt = 1'b0, cpu_idle = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] count;
  logic        flag, irq;
  logic [15:0] c0;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tbsel_counter dut (
    .clk(clk), .rst(rst), .t0_ovf_i(t0_ovf), .ext_clk_i(ext_clk),
    .ext_cnt_i(ext_cnt), .cpu_idle_i(cpu_idle), .mode_wr_i(wr),
    .mode_rd_i(rd), .mode_wdata_i(wdata), .mode_rdata_o(rdata),
    .ovf_clr_i(clr), .count_o(count), .ovf_flag_o(flag), .irq_o(irq));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic put_mode(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    step(1);
    wr = 1'b0;
  endtask

  initial begin
    step(1);
    do_reset();
    // R1 reset state
    rd = 1'b1;
    chk("R1 count", {16'h0, count}, 32'h0);
    chk("R1 flag", {31'h0, flag}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 mode", {24'h0, rdata}, 32'h0);
    // R2 readback masking
    put_mode(8'hFF);
    chk("R2 read 0xFF", {24'h0, rdata}, 32'h8F);
    rd = 1'b0; #1;
    chk("R2 no strobe", {24'h0, rdata}, 32'h0);
    rd = 1'b1;
    put_mode(8'h70);
    chk("R2 unused bits", {24'h0, rdata}, 32'h0);
    rd = 1'b0;

    // R3 slow prescale
    do_reset();
    put_mode(8'h00); c0 = count; step(120);
    chk("R3 /12 over 120", {16'h0, count - c0}, 32'd10);
    c0 = count; step(12);
    chk("R3 /12 over 12", {16'h0, count - c0}, 32'd1);
    // R4 fast prescale
    put_mode(8'h02); c0 = count; step(40);
    chk("R4 /4 over 40", {16'h0, count - c0}, 32'd10);
    // R7 system clock
    put_mode(8'h08); c0 = count; step(37);
    chk("R7 sysclk", {16'h0, count - c0}, 32'd37);
    // R9 reserved codes
    put_mode(8'h0C); c0 = count; step(30);
    chk("R9 code 110", {16'h0, count - c0}, 32'd0);
    put_mode(8'h0E); c0 = count; step(30);
    chk("R9 code 111", {16'h0, count - c0}, 32'd0);
    // R5 timer overflow pulses
    put_mode(8'h04); c0 = count;
    for (int i = 0; i < 7; i++) begin
      t0_ovf = 1'b1; step(1); t0_ovf = 1'b0; step(2);
    end
    chk("R5 t0 pulses", {16'h0, count - c0}, 32'd7);
    // R6 external count falling edges
    put_mode(8'h06); c0 = count;
    for (int i = 0; i < 6; i++) begin
      ext_cnt = 1'b1; step(3); ext_cnt = 1'b0; step(3);
    end
    step(5);
    chk("R6 falls", {16'h0, count - c0}, 32'd6);
    c0 = count; ext_cnt = 1'b1; step(10);
    chk("R6 steady high", {16'h0, count - c0}, 32'd0);
    ext_cnt = 1'b0; step(5);
    chk("R6 final fall", {16'h0, count - c0}, 32'd1);

    // R8 external clock / 8
    do_reset();
    put_mode(8'h0A); c0 = count;
    for (int i = 0; i < 16; i++) begin
      ext_clk = 1'b1; step(3); ext_clk = 1'b0; step(3);
    end
    step(6);
    chk("R8 16 edges", {16'h0, count - c0}, 32'd2);
    c0 = count;
    for (int i = 0; i < 7; i++) begin
      ext_clk = 1'b1; step(3); ext_clk = 1'b0; step(3);
    end
    step(6);
    chk("R8 7 edges", {16'h0, count - c0}, 32'd0);
    ext_clk = 1'b1; step(3); ext_clk = 1'b0; step(6);
    chk("R8 8th edge", {16'h0, count - c0}, 32'd1);

    // R10 idle suspension
    put_mode(8'h88); cpu_idle = 1'b1; c0 = count; step(20);
    chk("R10 frozen", {16'h0, count - c0}, 32'd0);
    cpu_idle = 1'b0; c0 = count; step(20);
    chk("R10 resumed", {16'h0, count - c0}, 32'd20);
    put_mode(8'h08); cpu_idle = 1'b1; c0 = count; step(20);
    chk("R10 ignored", {16'h0, count - c0}, 32'd20);
    cpu_idle = 1'b0;

    // R11 / R12 wrap, clear collision, interrupt mask
    do_reset();
    put_mode(8'h08);
    while (count != 16'hFFFE) step(1);
    chk("R11 no flag early", {31'h0, flag}, 32'h0);
    step(1);
    chk("R11 at top", {16'h0, count}, 32'hFFFF);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R11 wrapped", {16'h0, count}, 32'h0);
    chk("R11 set beats clear", {31'h0, flag}, 32'h1);
    chk("R12 masked", {31'h0, irq}, 32'h0);
    put_mode(8'h09);
    chk("R12 enabled", {31'h0, irq}, 32'h1);
    step(5);
    chk("R11 sticky", {31'h0, flag}, 32'h1);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R11 cleared", {31'h0, flag}, 32'h0);
    chk("R12 dropped", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule